// File: doc/BRIEF.md
# Multi-Channel SPI Configuration Register Bank

This block is the serial control front end of a four-channel output driver. A host sends 16-bit command frames over SPI. Each frame carries four fields:
- a watchdog toggle bit;
- a channel select;
- a register address;
- a data payload.

The bank decodes the frame and writes the payload into one of a set of per-channel registers or into one of two global registers. It presents the stored contents as decoded control outputs to the driver logic.

Reading works through the status address. A write to address 000 changes no configuration. It only latches a 5-bit readback selector. At the start of every following frame, the word chosen by that selector is loaded into the transmit shifter and returned on MISO, MSB first. The word is either the external device status word or the contents of one stored register.

The SPI pins are sampled in the system clock domain. A frame is accepted only if exactly sixteen SCLK rising edges occur while chip select is low. Frames of any other length are dropped. Supply failure and the reset pin both return every register to zero.

The framing controller is a state machine with these states:
- **ST_IDLE**: chip select is high.
- **ST_LOAD**: chip select has fallen and the readback word is being captured.
- **ST_SHIFT**: bits are moving in both directions.
- **ST_COMMIT**: chip select rose after exactly 16 edges and the frame is written.
- **ST_DROP**: chip select rose after any other count and the frame is discarded.

It has these transitions:
- ST_IDLE→ST_LOAD on a chip-select fall.
- ST_LOAD→ST_SHIFT always.
- ST_SHIFT→ST_COMMIT or ST_SHIFT→ST_DROP on a chip-select rise, depending on the bit count.
- ST_COMMIT→ST_IDLE and ST_DROP→ST_IDLE always.

Top module: `spi_cfg_bank`

## Requirements
- R1: A frame is captured MSB first on SCLK rising edges while CS_N is low. Its fields are: bit 15 is the watchdog bit, bits 14:13 are the channel (00 selects channel 0 through 11 for channel 3), bits 12:10 are the address, and bits 8:0 are the payload. Bit 9 is ignored.
- R2: A frame is written only when CS_N rises after exactly 16 SCLK rising edges. A frame with fewer or more edges changes no register, selector or watchdog bit.
- R3: Address 001 is the channel PWM register. Payload bit 8 drives `ch_lowpwr`, bit 7 drives `ch_on`, and bits 6:0 drive the 7-bit duty field of that channel.
- R4: Address 010 is channel configuration 0. Payload bit 5 drives `ch_dir_dis` and bits 2:0 drive the 3-bit delay code. All other payload bits are discarded and read back as zero.
- R5: The remaining writable addresses are:
  - 011, channel configuration 1: bits 6:0 stored per channel.
  - 100, channel overcurrent: bits 8:0 stored per channel.
  - 101, global configuration: bits 7:0, with the channel field ignored.
  - 110, calibration: bits 8:0, global, with the channel field ignored.
- R6: A frame to address 000 changes no configuration register. Its bits 4:0 become the readback selector.
- R7: When CS_N falls, a 16-bit word is loaded and shifted out MSB first on MISO, advancing after each SCLK falling edge. The word depends on selector bits 2:0:
  - 000 returns `dev_status`.
  - Any other value returns {0, selector[4:3] as channel, selector[2:0] as address, 0, nine data bits}. The data bits are the stored register of that channel and address, or zero for address 111.
- R8: Writes to address 111 are ignored.
- R9: `wd_bit` equals bit 15 of the last written frame, including frames to address 000.
- R10: `rst_n` low, or `supply_fail` high for one clock, clears every register, the selector and `wd_bit` to zero.
- R11: MISO is 0 while the frame controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_fail | input | 1 | Synchronous clear of all state |
| spi_sclk | input | 1 | SPI clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| dev_status | input | 16 | Device status word returned for selector address 000 |
| wd_bit | output | 1 | Watchdog bit of the last written frame |
| ch_on | output | 4 | Channel on bits |
| ch_lowpwr | output | 4 | Reduced-power protection profile per channel |
| ch_duty | output | 28 | 7-bit duty per channel, channel 0 in bits 6:0 |
| ch_dir_dis | output | 4 | Direct-input control disable per channel |
| ch_delay | output | 12 | 3-bit switching delay per channel |
| ch_cfg1 | output | 28 | 7-bit configuration 1 per channel |
| ch_ocr | output | 36 | 9-bit overcurrent setting per channel |
| glb_cfg | output | 8 | Global configuration |
| cal_cfg | output | 9 | Calibration setting |

## Verification
The bound checker watches every cycle for several conditions:
- A write happens only with a count of exactly sixteen.
- Status and unused-address writes leave all storage unchanged.
- Nothing changes without a write, apart from a clear.
- The selector and the watchdog bit follow the written frame.
- A supply failure empties everything.
- MISO stays low when idle.

Some behaviour only the bench scenarios can show:
- whether the serial bit order and field positions decode into the right outputs;
- whether the masks per address are correct;
- whether the word shifted out in a frame matches the selector latched by an earlier frame.

For these the bench compares each returned MISO word and every output group against a model, across directed frames, short and long frames and random traffic.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

    localparam int FRAME_BITS = 16;
    localparam int CH_W       = 2;
    localparam int NCH        = 1 << CH_W;
    localparam int ADDR_W     = 3;
    localparam int DATA_W     = 9;
    localparam int SEL_W      = 5;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);
    localparam int CH_REGS    = 4;
    localparam int GL_REGS    = 2;
    localparam int GL_BASE    = CH_REGS + 1;

    // Frame field positions
    localparam int WD_POS     = FRAME_BITS - 1;
    localparam int CH_LSB     = 13;
    localparam int ADDR_LSB   = 10;

    // Payload field positions
    localparam int PWM_LP_POS  = 8;
    localparam int PWM_ON_POS  = 7;
    localparam int DUTY_W      = 7;
    localparam int DIRDIS_POS  = 5;
    localparam int DELAY_W     = 3;
    localparam int CFG1_W      = 7;
    localparam int GLB_W       = 8;

    typedef enum logic [ADDR_W-1:0] {
        RA_STAT = 3'd0,
        RA_PWM  = 3'd1,
        RA_CFG0 = 3'd2,
        RA_CFG1 = 3'd3,
        RA_OCR  = 3'd4,
        RA_GLB  = 3'd5,
        RA_CAL  = 3'd6,
        RA_NONE = 3'd7
    } reg_addr_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_COMMIT,
        ST_DROP
    } fsm_state_e;

    function automatic logic [DATA_W-1:0] wr_mask(input logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] m;
        unique case (a)
            RA_PWM:  m = DATA_W'(9'h1FF);
            RA_CFG0: m = DATA_W'(9'h027);
            RA_CFG1: m = DATA_W'(9'h07F);
            RA_OCR:  m = DATA_W'(9'h1FF);
            RA_GLB:  m = DATA_W'(9'h0FF);
            RA_CAL:  m = DATA_W'(9'h1FF);
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import spi_cfg_pkg::*;
#(
    parameter int NBITS = FRAME_BITS,
    parameter int CW    = CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             mosi,
    input  logic [NBITS-1:0] load_word,
    output logic             miso,
    output logic             commit,
    output logic [NBITS-1:0] frame,
    output fsm_state_e       state_o,
    output logic [CW-1:0]    bit_cnt_o
);

    localparam logic [CW-1:0] CNT_FULL = CW'(NBITS);
    localparam logic [CW-1:0] CNT_SAT  = CW'(NBITS + 1);

    logic [2:0] sclk_q;
    logic [2:0] cs_q;
    logic [1:0] mosi_q;
    logic       sclk_rise, sclk_fall, cs_fall, cs_rise;

    fsm_state_e       state, nxt;
    logic [NBITS-1:0] rx_sh, tx_sh;
    logic [CW-1:0]    cnt;

    // Pin synchronisers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
        end else begin
            sclk_q <= {sclk_q[1:0], sclk};
            cs_q   <= {cs_q[1:0], cs_n};
            mosi_q <= {mosi_q[0], mosi};
        end
    end

    assign sclk_rise = sclk_q[1] & ~sclk_q[2];
    assign sclk_fall = ~sclk_q[1] & sclk_q[2];
    assign cs_fall   = ~cs_q[1] & cs_q[2];
    assign cs_rise   = cs_q[1] & ~cs_q[2];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state <= ST_IDLE;
        else if (clr) state <= ST_IDLE;
        else          state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (cs_fall) nxt = ST_LOAD;
            ST_LOAD:   nxt = ST_SHIFT;
            ST_SHIFT:  if (cs_rise) nxt = (cnt == CNT_FULL) ? ST_COMMIT : ST_DROP;
            ST_COMMIT: nxt = ST_IDLE;
            ST_DROP:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Shifters and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh <= '0;
            tx_sh <= '0;
            cnt   <= '0;
        end else if (clr) begin
            rx_sh <= '0;
            tx_sh <= '0;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_LOAD: begin
                    tx_sh <= load_word;
                    rx_sh <= '0;
                    cnt   <= '0;
                end
                ST_SHIFT: begin
                    if (sclk_rise) begin
                        rx_sh <= {rx_sh[NBITS-2:0], mosi_q[1]};
                        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
                    end
                    if (sclk_fall) tx_sh <= {tx_sh[NBITS-2:0], 1'b0};
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        commit    = (state == ST_COMMIT);
        miso      = (state == ST_SHIFT) ? tx_sh[NBITS-1] : 1'b0;
        frame     = rx_sh;
        state_o   = state;
        bit_cnt_o = cnt;
    end

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import spi_cfg_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clr,
    input  logic                              commit,
    input  logic [FRAME_BITS-1:0]             frame,
    output logic [NCH*CH_REGS*DATA_W-1:0]     ch_regs,
    output logic [GL_REGS*DATA_W-1:0]         gl_regs,
    output logic [SEL_W-1:0]                  rb_sel,
    output logic                              wd_bit
);

    logic [CH_W-1:0]   f_ch;
    logic [ADDR_W-1:0] f_addr;
    logic [DATA_W-1:0] f_data;

    assign f_ch   = frame[CH_LSB +: CH_W];
    assign f_addr = frame[ADDR_LSB +: ADDR_W];
    assign f_data = frame[DATA_W-1:0];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        for (genvar r = 0; r < CH_REGS; r++) begin : g_reg
            localparam logic [ADDR_W-1:0] RA = ADDR_W'(r + 1);
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   q <= '0;
                else if (clr) q <= '0;
                else if (commit && f_ch == CH_W'(c) && f_addr == RA)
                    q <= f_data & wr_mask(RA);
            end
            assign ch_regs[(c*CH_REGS + r)*DATA_W +: DATA_W] = q;
        end
    end

    for (genvar g = 0; g < GL_REGS; g++) begin : g_glb
        localparam logic [ADDR_W-1:0] RA = ADDR_W'(g + GL_BASE);
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (clr) q <= '0;
            else if (commit && f_addr == RA)
                q <= f_data & wr_mask(RA);
        end
        assign gl_regs[g*DATA_W +: DATA_W] = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_sel <= '0;
            wd_bit <= 1'b0;
        end else if (clr) begin
            rb_sel <= '0;
            wd_bit <= 1'b0;
        end else if (commit) begin
            wd_bit <= frame[WD_POS];
            if (f_addr == RA_STAT) rb_sel <= frame[SEL_W-1:0];
        end
    end

endmodule

// File: rtl/rb_mux.sv
module rb_mux
    import spi_cfg_pkg::*;
(
    input  logic [SEL_W-1:0]              sel,
    input  logic [FRAME_BITS-1:0]         dev_status,
    input  logic [NCH*CH_REGS*DATA_W-1:0] ch_regs,
    input  logic [GL_REGS*DATA_W-1:0]     gl_regs,
    output logic [FRAME_BITS-1:0]         word
);

    localparam int PAD_W = FRAME_BITS - CH_W - ADDR_W - DATA_W - 1;

    logic [ADDR_W-1:0] s_addr;
    logic [CH_W-1:0]   s_ch;
    logic [DATA_W-1:0] data;
    int                idx;

    assign s_addr = sel[ADDR_W-1:0];
    assign s_ch   = sel[ADDR_W +: CH_W];

    always_comb begin
        data = '0;
        idx  = 0;
        if (s_addr >= ADDR_W'(RA_PWM) && s_addr <= ADDR_W'(CH_REGS)) begin
            idx  = int'(s_ch) * CH_REGS + int'(s_addr) - 1;
            data = ch_regs[idx*DATA_W +: DATA_W];
        end else if (s_addr == RA_GLB || s_addr == RA_CAL) begin
            idx  = int'(s_addr) - GL_BASE;
            data = gl_regs[idx*DATA_W +: DATA_W];
        end
        if (s_addr == RA_STAT) word = dev_status;
        else word = {{PAD_W{1'b0}}, s_ch, s_addr, 1'b0, data};
    end

endmodule

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank
    import spi_cfg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     supply_fail,
    input  logic                     spi_sclk,
    input  logic                     spi_cs_n,
    input  logic                     spi_mosi,
    output logic                     spi_miso,
    input  logic [15:0]              dev_status,
    output logic                     wd_bit,
    output logic [3:0]               ch_on,
    output logic [3:0]               ch_lowpwr,
    output logic [27:0]              ch_duty,
    output logic [3:0]               ch_dir_dis,
    output logic [11:0]              ch_delay,
    output logic [27:0]              ch_cfg1,
    output logic [35:0]              ch_ocr,
    output logic [7:0]               glb_cfg,
    output logic [8:0]               cal_cfg
);

    fsm_state_e                   fsm_state;
    logic                         commit;
    logic [FRAME_BITS-1:0]        frame;
    logic [FRAME_BITS-1:0]        rb_word;
    logic [CNT_W-1:0]             bit_cnt;
    logic [NCH*CH_REGS*DATA_W-1:0] ch_regs;
    logic [GL_REGS*DATA_W-1:0]    gl_regs;
    logic [SEL_W-1:0]             rb_sel;

    spi_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (supply_fail),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .load_word (rb_word),
        .miso      (spi_miso),
        .commit    (commit),
        .frame     (frame),
        .state_o   (fsm_state),
        .bit_cnt_o (bit_cnt)
    );

    cfg_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (supply_fail),
        .commit  (commit),
        .frame   (frame),
        .ch_regs (ch_regs),
        .gl_regs (gl_regs),
        .rb_sel  (rb_sel),
        .wd_bit  (wd_bit)
    );

    rb_mux u_rb (
        .sel        (rb_sel),
        .dev_status (dev_status),
        .ch_regs    (ch_regs),
        .gl_regs    (gl_regs),
        .word       (rb_word)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_out
        localparam int PWM_B  = (c*CH_REGS + 0) * DATA_W;
        localparam int CFG0_B = (c*CH_REGS + 1) * DATA_W;
        localparam int CFG1_B = (c*CH_REGS + 2) * DATA_W;
        localparam int OCR_B  = (c*CH_REGS + 3) * DATA_W;
        assign ch_lowpwr[c]                 = ch_regs[PWM_B + PWM_LP_POS];
        assign ch_on[c]                     = ch_regs[PWM_B + PWM_ON_POS];
        assign ch_duty[c*DUTY_W +: DUTY_W]  = ch_regs[PWM_B +: DUTY_W];
        assign ch_dir_dis[c]                = ch_regs[CFG0_B + DIRDIS_POS];
        assign ch_delay[c*DELAY_W +: DELAY_W] = ch_regs[CFG0_B +: DELAY_W];
        assign ch_cfg1[c*CFG1_W +: CFG1_W]  = ch_regs[CFG1_B +: CFG1_W];
        assign ch_ocr[c*DATA_W +: DATA_W]   = ch_regs[OCR_B +: DATA_W];
    end

    assign glb_cfg = gl_regs[GLB_W-1:0];
    assign cal_cfg = gl_regs[DATA_W +: DATA_W];

endmodule

// File: rtl/spi_cfg_bank_chk.sv
module spi_cfg_bank_chk
    import spi_cfg_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          supply_fail,
    input fsm_state_e                    state,
    input logic                          commit,
    input logic [FRAME_BITS-1:0]         frame,
    input logic [CNT_W-1:0]              bit_cnt,
    input logic [NCH*CH_REGS*DATA_W-1:0] ch_regs,
    input logic [GL_REGS*DATA_W-1:0]     gl_regs,
    input logic [SEL_W-1:0]              rb_sel,
    input logic                          wd_bit,
    input logic                          spi_miso
);

    logic [ADDR_W-1:0] f_addr;
    assign f_addr = frame[ADDR_LSB +: ADDR_W];

    a_r2_commit_len: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> bit_cnt == CNT_W'(FRAME_BITS));

    a_r2_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !supply_fail) |=> ($stable(ch_regs) && $stable(gl_regs)
                                       && $stable(rb_sel) && $stable(wd_bit)));

    a_r6_status_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !supply_fail && f_addr == RA_STAT) |=> ($stable(ch_regs) && $stable(gl_regs)));

    a_r6_sel_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !supply_fail && f_addr == RA_STAT) |=> rb_sel == $past(frame[SEL_W-1:0]));

    a_r8_unused_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !supply_fail && f_addr == RA_NONE) |=> ($stable(ch_regs) && $stable(gl_regs)));

    a_r9_wd_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !supply_fail) |=> wd_bit == $past(frame[WD_POS]));

    a_r10_supply_clear: assert property (@(posedge clk) disable iff (!rst_n)
        supply_fail |=> (ch_regs == '0 && gl_regs == '0 && rb_sel == '0 && !wd_bit));

    a_r11_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !spi_miso);

endmodule

bind spi_cfg_bank spi_cfg_bank_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_fail (supply_fail),
    .state       (fsm_state),
    .commit      (commit),
    .frame       (frame),
    .bit_cnt     (bit_cnt),
    .ch_regs     (ch_regs),
    .gl_regs     (gl_regs),
    .rb_sel      (rb_sel),
    .wd_bit      (wd_bit),
    .spi_miso    (spi_miso)
);

// File: tb/tb_spi_cfg_bank.sv
module tb_spi_cfg_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        supply_fail = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic [15:0] dev_status = 16'hA5C3;
    logic        wd_bit;
    logic [3:0]  ch_on, ch_lowpwr, ch_dir_dis;
    logic [27:0] ch_duty, ch_cfg1;
    logic [11:0] ch_delay;
    logic [35:0] ch_ocr;
    logic [7:0]  glb_cfg;
    logic [8:0]  cal_cfg;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Model
    logic [8:0] m_ch [4][4];
    logic [8:0] m_gl [2];
    logic [4:0] m_sel;
    logic       m_wd;

    always #10 clk = ~clk;

    spi_cfg_bank dut (
        .clk(clk), .rst_n(rst_n), .supply_fail(supply_fail),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .dev_status(dev_status), .wd_bit(wd_bit),
        .ch_on(ch_on), .ch_lowpwr(ch_lowpwr), .ch_duty(ch_duty),
        .ch_dir_dis(ch_dir_dis), .ch_delay(ch_delay), .ch_cfg1(ch_cfg1),
        .ch_ocr(ch_ocr), .glb_cfg(glb_cfg), .cal_cfg(cal_cfg)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] ev);
        n_tests++;
        if (act !== ev) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, ev);
        end
    endtask

    task automatic model_clear();
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++) m_ch[c][r] = '0;
        m_gl[0] = '0; m_gl[1] = '0; m_sel = '0; m_wd = 1'b0;
    endtask

    function automatic logic [15:0] exp_rb();
        logic [2:0] a = m_sel[2:0];
        logic [1:0] c = m_sel[4:3];
        logic [8:0] d = '0;
        if (a >= 3'd1 && a <= 3'd4) d = m_ch[c][a-3'd1];
        else if (a == 3'd5) d = m_gl[0];
        else if (a == 3'd6) d = m_gl[1];
        if (a == 3'd0) return dev_status;
        return {1'b0, c, a, 1'b0, d};
    endfunction

    task automatic model_apply(input logic [15:0] w);
        logic [2:0] a = w[12:10];
        logic [1:0] c = w[14:13];
        logic [8:0] d = w[8:0];
        m_wd = w[15];
        case (a)
            3'd0: m_sel = w[4:0];
            3'd1: m_ch[c][0] = d;
            3'd2: m_ch[c][1] = d & 9'h027;
            3'd3: m_ch[c][2] = d & 9'h07F;
            3'd4: m_ch[c][3] = d;
            3'd5: m_gl[0] = d & 9'h0FF;
            3'd6: m_gl[1] = d;
            default: ;
        endcase
    endtask

    task automatic check_outs(input string tag);
        logic [35:0] e_pwm; logic [15:0] e_c0; logic [63:0] e_c1o; logic [16:0] e_gl;
        logic [3:0] e_on, e_lp, e_dir; logic [27:0] e_duty, e_cfg1; logic [11:0] e_dly;
        logic [35:0] e_oc;
        for (int c = 0; c < 4; c++) begin
            e_on[c] = m_ch[c][0][7];
            e_lp[c] = m_ch[c][0][8];
            e_duty[c*7 +: 7] = m_ch[c][0][6:0];
            e_dir[c] = m_ch[c][1][5];
            e_dly[c*3 +: 3] = m_ch[c][1][2:0];
            e_cfg1[c*7 +: 7] = m_ch[c][2][6:0];
            e_oc[c*9 +: 9] = m_ch[c][3];
        end
        e_pwm = {e_lp, e_on, e_duty};
        e_c0  = {e_dir, e_dly};
        e_c1o = {e_cfg1, e_oc};
        e_gl  = {m_gl[0][7:0], m_gl[1]};
        chk({"R3 pwm outputs ", tag}, 64'({ch_lowpwr, ch_on, ch_duty}), 64'(e_pwm));
        chk({"R4 cfg0 outputs ", tag}, 64'({ch_dir_dis, ch_delay}), 64'(e_c0));
        chk({"R5 channel cfg1/ocr ", tag}, {ch_cfg1, ch_ocr}, e_c1o);
        chk({"R5 global regs ", tag}, 64'({glb_cfg, cal_cfg}), 64'(e_gl));
        chk({"R9 wd_bit ", tag}, 64'(wd_bit), 64'(m_wd));
    endtask

    // R1 serial frame: nbits SCLK pulses, MSB first; returns first 16 MISO bits
    task automatic send_frame(input logic [15:0] w, input int nbits, output logic [15:0] got);
        got = '0;
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < 16) ? w[15-i] : 1'b0;
            repeat (6) @(negedge clk);
            if (i < 16) got[15-i] = spi_miso;
            spi_sclk = 1'b1;
            repeat (6) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (6) @(negedge clk);
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    // Full frame with readback check and model update
    task automatic do_frame(input logic [15:0] w, input string tag);
        logic [15:0] got, ev;
        ev = exp_rb();
        send_frame(w, 16, got);
        chk({"R7 readback ", tag}, 64'(got), 64'(ev));
        model_apply(w);
        check_outs(tag);
    endtask

    initial begin
        logic [15:0] got;
        void'($urandom(32'd2024));
        model_clear();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R10 reset state, R11 idle MISO
        check_outs("after reset");
        chk("R11 miso idle", 64'(spi_miso), 64'(0));

        // R6 select ch2 PWM for next frame; first readback is device status
        do_frame({1'b1, 2'b00, 3'b000, 5'b0, 5'b10_001}, "status select");
        // R3 PWM ch2 full payload plus bit 9
        do_frame({1'b0, 2'b10, 3'b001, 1'b1, 9'h1AB}, "pwm ch2");
        // R7 readback of ch2 PWM now
        do_frame({1'b1, 2'b00, 3'b000, 5'b0, 5'b11_010}, "read pwm ch2");
        // R4 cfg0 ch3 with all bits set: only 027 kept
        do_frame({1'b0, 2'b11, 3'b010, 1'b1, 9'h1FF}, "cfg0 ch3 mask");
        do_frame({1'b0, 2'b00, 3'b000, 5'b0, 5'b00_101}, "sel glb");
        // R5 global written with channel 3 field, read back with channel 0 selector
        do_frame({1'b1, 2'b11, 3'b101, 1'b0, 9'h1FF}, "glb ch field ignored");
        do_frame({1'b0, 2'b01, 3'b110, 1'b0, 9'h155}, "cal");
        do_frame({1'b1, 2'b01, 3'b011, 1'b0, 9'h1C3}, "cfg1 ch1");
        do_frame({1'b0, 2'b00, 3'b100, 1'b0, 9'h0F1}, "ocr ch0");
        // R8 unused address write ignored, readback data zero
        do_frame({1'b0, 2'b00, 3'b000, 5'b0, 5'b01_111}, "sel unused");
        do_frame({1'b1, 2'b01, 3'b111, 1'b1, 9'h1FF}, "R8 write unused");

        // R2 short and long frames discarded
        send_frame({1'b0, 2'b10, 3'b001, 1'b0, 9'h000}, 10, got);
        check_outs("R2 short frame");
        send_frame({1'b0, 2'b10, 3'b001, 1'b0, 9'h000}, 20, got);
        check_outs("R2 long frame");
        send_frame({1'b0, 2'b10, 3'b001, 1'b0, 9'h000}, 15, got);
        check_outs("R2 15-bit frame");

        // Random traffic (R1, R3..R9)
        for (int k = 0; k < 240; k++) begin
            logic [15:0] w;
            int sel;
            w = 16'($urandom);
            sel = int'($urandom % 10);
            if ($urandom % 4 == 0) dev_status = 16'($urandom);
            if (sel == 0) begin
                send_frame(w, 16 + ((($urandom % 2) == 0) ? -3 : 2), got);
                check_outs("R2 random bad length");
            end else begin
                do_frame(w, "random");
            end
            chk("R11 miso idle between frames", 64'(spi_miso), 64'(0));
        end

        // R10 supply failure clears everything, selector back to status
        do_frame({1'b1, 2'b10, 3'b100, 1'b0, 9'h1EE}, "pre fail");
        @(negedge clk);
        supply_fail = 1'b1;
        @(negedge clk);
        supply_fail = 1'b0;
        repeat (4) @(negedge clk);
        model_clear();
        check_outs("R10 supply fail");
        dev_status = 16'h3C5A;
        do_frame({1'b0, 2'b00, 3'b001, 1'b0, 9'h080}, "R10 readback after fail");

        // R10 reset pin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        model_clear();
        check_outs("R10 rst_n");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule